// File: doc/BRIEF.md
# Receiver Power-Down and Lock Sequencer

This block decides what the parallel outputs of a serial-link receiver do at any moment. It watches an active-low power-down pin, the received parallel-rate clock and its own lock counter. From these it produces two controls for the output pads: an output enable and a force-low command. The pads themselves, the data path and the real phase-locked loop sit outside this block.

The sequencer has three states. OFF leaves the pads in high impedance and holds the lock logic idle. LOCKING drives the pads low while a counter counts rising edges of the received clock. RUN lets live data through. The block leaves OFF when the synchronized power-down pin goes high. It moves from LOCKING to RUN once the counter reaches its fixed count. It returns to LOCKING from RUN when the received clock stops or runs too slowly. It returns to OFF from either active state as soon as power-down is seen asserted. The received clock is treated as an asynchronous signal. A clock monitor samples it on the free-running system clock and flags a loss when no rising edge arrives within a set number of system cycles.

Top module: `rx_pwr_seq`

## Requirements
- R1: After reset the sequencer is in OFF, with `out_en` = 0 (pads high impedance) and `force_low` = 1.
- R2: While the synchronized `pd_n` is 0, `out_en` stays 0 whatever `rx_clk` does, and the lock counter is held at zero.
- R3: OFF to LOCKING: once the synchronized `pd_n` is 1, the state becomes LOCKING, with `out_en` = 1 and `force_low` = 1 (pads driven low). This holds even when `rx_clk` is idle.
- R4: LOCKING to RUN: the transition happens after exactly `LOCK_CYCLES` rising edges of `rx_clk` have been counted in LOCKING while the clock was good. RUN has `out_en` = 1 and `force_low` = 0.
- R5: RUN to LOCKING: when `LOSS_LIMIT` system cycles pass with no rising edge of `rx_clk` (clock stopped or too slow), the state leaves RUN for LOCKING on the next cycle, so `force_low` = 1. While the loss lasts, the state cannot enter RUN.
- R6: The sequence works in either order. Power-down may be released before the clock starts, or the clock may run before power-down is released. Both cases lock after `LOCK_CYCLES` edges seen in LOCKING.
- R7: The lock counter restarts from zero whenever power-down is asserted or clock loss is detected. Edges counted before the interruption do not count toward the next lock.
- R8: `pd_n` passes through a two-flop synchronizer. After `pd_n` falls, `out_en` is still 1 after the first and second system-clock edges and is 0 after the third. At 200 MHz this is 15 ns, well inside 100 ns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pd_n | input | 1 | Power-down pin, asynchronous; 0 = power down, 1 = operate |
| rx_clk | input | 1 | Received parallel-rate clock, asynchronous to `clk` |
| out_en | output | 1 | 1 = output pads driven, 0 = high impedance |
| force_low | output | 1 | 1 = driven pads held low, 0 = live data passes |

## Verification
The received clock is driven in several patterns:
- **Nominal period:** lock is checked one edge before the count (`LOCK_CYCLES` − 1 edges) and exactly at it, which separates an exact edge count from an early or late one.
- **Stopped and too slow:** separate patterns show that loss detection forces the outputs low from RUN, and that a slow but toggling clock never reaches lock.
- **Power-down ordering:** the release comes once before the clock starts and once after it is already running. Power-down is also pulsed partway through a lock. Both show the counter restarting from zero instead of resuming.
- **Power-down fall:** the enable is sampled after each of the first three system edges, which pins the synchronizer depth.

// File: rtl/rx_pwr_seq_pkg.sv
package rx_pwr_seq_pkg;

    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_LOCKING = 2'd1,
        ST_RUN     = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic out_en;
        logic force_low;
    } pad_ctl_t;

endpackage

// File: rtl/rps_sync.sv
module rps_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rps_clk_mon.sv
module rps_clk_mon #(
    parameter int SYNC_STAGES = 2,
    parameter int LOSS_LIMIT  = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_clk,
    output logic rise,
    output logic clk_ok
);
    localparam int LW = $clog2(LOSS_LIMIT + 1);
    localparam logic [LW-1:0] LIMIT = LW'(LOSS_LIMIT);

    logic          rx_s;
    logic          rx_d;
    logic [LW-1:0] idle_cnt;

    rps_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rx_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rx_clk),
        .q     (rx_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_d <= 1'b0;
        end else begin
            rx_d <= rx_s;
        end
    end

    assign rise = rx_s & ~rx_d;

    // idle counter: cycles since the last rising edge, saturating at the limit;
    // starts saturated so an absent clock is reported as lost after reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_cnt <= LIMIT;
        end else if (rise) begin
            idle_cnt <= '0;
        end else if (idle_cnt < LIMIT) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    assign clk_ok = rise | (idle_cnt < LIMIT);
endmodule

// File: rtl/rps_lock_cnt.sv
module rps_lock_cnt #(
    parameter int LOCK_CYCLES = 32800,
    localparam int CW = $clog2(LOCK_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    output logic          done,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] TARGET = CW'(LOCK_CYCLES);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (step && (count != TARGET)) begin
            count <= count + 1'b1;
        end
    end

    assign done = (count == TARGET);
endmodule

// File: rtl/rx_pwr_seq.sv
module rx_pwr_seq
    import rx_pwr_seq_pkg::*;
#(
    parameter int LOCK_CYCLES = 32800,
    parameter int LOSS_LIMIT  = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_n,
    input  logic rx_clk,
    output logic out_en,
    output logic force_low
);
    localparam int CW = $clog2(LOCK_CYCLES + 1);

    seq_state_e    state;
    seq_state_e    state_nx;
    pad_ctl_t      pad;
    logic          pd_s;
    logic          rx_rise;
    logic          clk_ok;
    logic          clk_lost;
    logic          lock_done;
    logic          lock_clear;
    logic [CW-1:0] lock_cnt;

    rps_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pd_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pd_n),
        .q     (pd_s)
    );

    rps_clk_mon #(.SYNC_STAGES(SYNC_STAGES), .LOSS_LIMIT(LOSS_LIMIT)) u_clk_mon (
        .clk    (clk),
        .rst_n  (rst_n),
        .rx_clk (rx_clk),
        .rise   (rx_rise),
        .clk_ok (clk_ok)
    );

    assign clk_lost   = ~clk_ok;
    assign lock_clear = (state != ST_LOCKING) | clk_lost;

    rps_lock_cnt #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (lock_clear),
        .step  (rx_rise),
        .done  (lock_done),
        .count (lock_cnt)
    );

    // next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF: begin
                if (pd_s) state_nx = ST_LOCKING;
            end
            ST_LOCKING: begin
                if (!pd_s)                       state_nx = ST_OFF;
                else if (lock_done && !clk_lost) state_nx = ST_RUN;
            end
            ST_RUN: begin
                if (!pd_s)         state_nx = ST_OFF;
                else if (clk_lost) state_nx = ST_LOCKING;
            end
            default: state_nx = ST_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            state <= state_nx;
        end
    end

    // output decode
    always_comb begin
        pad = '{out_en: 1'b0, force_low: 1'b1};
        unique case (state)
            ST_OFF:     pad = '{out_en: 1'b0, force_low: 1'b1};
            ST_LOCKING: pad = '{out_en: 1'b1, force_low: 1'b1};
            ST_RUN:     pad = '{out_en: 1'b1, force_low: 1'b0};
            default:    pad = '{out_en: 1'b0, force_low: 1'b1};
        endcase
    end

    assign out_en    = pad.out_en;
    assign force_low = pad.force_low;
endmodule

// File: rtl/rx_pwr_seq_chk.sv
module rx_pwr_seq_chk #(
    parameter int LOCK_CYCLES = 32800,
    localparam int CW = $clog2(LOCK_CYCLES + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pd_n,
    input logic          out_en,
    input logic          force_low,
    input logic          clk_lost,
    input logic [CW-1:0] lock_cnt
);
    // R8: three sampled low values of pd_n mean the pads are released
    p_pd_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(pd_n, 1) && !$past(pd_n, 2) && !$past(pd_n, 3)) |-> !out_en);

    // R2: a disabled pad is never released for live data
    p_off_forced_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> force_low);

    // R2, R7: the lock counter is empty one cycle after any OFF cycle
    p_cnt_clr_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |=> (lock_cnt == '0));

    // R4: live data starts only from an enabled state with a full count
    p_run_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(force_low) |-> ($past(out_en) && ($past(lock_cnt) == CW'(LOCK_CYCLES))));

    // R5: a detected loss forces the pads low on the next cycle
    p_loss_forces_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clk_lost |=> force_low);
endmodule

bind rx_pwr_seq rx_pwr_seq_chk #(.LOCK_CYCLES(LOCK_CYCLES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pd_n      (pd_n),
    .out_en    (out_en),
    .force_low (force_low),
    .clk_lost  (clk_lost),
    .lock_cnt  (lock_cnt)
);

// File: tb/rx_pwr_seq_test.sv
module rx_pwr_seq_test;
    localparam int LOCK_N = 16;
    localparam int LOSS_N = 20;
    localparam int WD_CYC = 100000;

    typedef struct {
        logic  en;
        logic  fl;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pd_n = 1'b0;
    logic rx_clk = 1'b0;
    logic out_en;
    logic force_low;

    int   n_checks = 0;
    int   n_errors = 0;
    bit   finished = 1'b0;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    rx_pwr_seq #(.LOCK_CYCLES(LOCK_N), .LOSS_LIMIT(LOSS_N), .SYNC_STAGES(2)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pd_n      (pd_n),
        .rx_clk    (rx_clk),
        .out_en    (out_en),
        .force_low (force_low)
    );

    // monitor: pops one expected item per falling edge and compares
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_checks++;
                if (out_en !== e.en || force_low !== e.fl) begin
                    n_errors++;
                    $display("FAIL %s: out_en=%b force_low=%b expected out_en=%b force_low=%b",
                             e.tag, out_en, force_low, e.en, e.fl);
                end
            end
        end
    end

    task automatic expect_pads(input logic en, input logic fl, input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        e.en = en; e.fl = fl; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rx_periods(input int n, input int half);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); rx_clk = 1'b1;
            repeat (half - 1) @(negedge clk);
            @(negedge clk); rx_clk = 1'b0;
            repeat (half - 1) @(negedge clk);
        end
    endtask

    initial begin
        idle(5);
        rst_n = 1'b1;
        expect_pads(1'b0, 1'b1, "R1 reset state");

        rx_periods(6, 4);
        expect_pads(1'b0, 1'b1, "R2 clock ignored while powered down");

        @(negedge clk); pd_n = 1'b1;
        idle(30);
        expect_pads(1'b1, 1'b1, "R3 release without clock");
        idle(50);
        expect_pads(1'b1, 1'b1, "R6 release before clock stays low");

        rx_periods(LOCK_N - 1, 4);
        expect_pads(1'b1, 1'b1, "R4 one edge short of lock");
        rx_periods(1, 4);
        expect_pads(1'b1, 1'b0, "R4 lock at exact count");

        idle(30);
        expect_pads(1'b1, 1'b1, "R5 stopped clock forces low");

        rx_periods(LOCK_N - 1, 4);
        expect_pads(1'b1, 1'b1, "R7 count restarted after loss");
        rx_periods(1, 4);
        expect_pads(1'b1, 1'b0, "R7 relock after loss");

        rx_periods(5, 20);
        expect_pads(1'b1, 1'b1, "R5 slow clock forces low");

        rx_periods(LOCK_N, 4);
        expect_pads(1'b1, 1'b0, "R4 relock after slow clock");

        @(negedge clk); pd_n = 1'b0;
        expect_pads(1'b1, 1'b0, "R8 first edge after power-down");
        expect_pads(1'b1, 1'b0, "R8 second edge after power-down");
        expect_pads(1'b0, 1'b1, "R8 third edge releases pads");

        rx_periods(5, 4);
        expect_pads(1'b0, 1'b1, "R2 running clock while powered down");

        @(negedge clk); pd_n = 1'b1;
        idle(4);
        rx_periods(LOCK_N - 1, 4);
        expect_pads(1'b1, 1'b1, "R6 clock first, short of lock");
        rx_periods(1, 4);
        expect_pads(1'b1, 1'b0, "R6 clock first, locked");

        @(negedge clk); pd_n = 1'b0;
        idle(6);
        @(negedge clk); pd_n = 1'b1;
        idle(4);
        rx_periods(10, 4);
        @(negedge clk); pd_n = 1'b0;
        idle(6);
        @(negedge clk); pd_n = 1'b1;
        idle(4);
        rx_periods(LOCK_N - 1, 4);
        expect_pads(1'b1, 1'b1, "R7 count restarted after power-down pulse");
        rx_periods(1, 4);
        expect_pads(1'b1, 1'b0, "R7 relock after power-down pulse");

        idle(3);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule